// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block is the register file and transaction sequencer that sits between software and a byte-level serial engine in an SMBus host. Software fills in the target address, the command byte and the outgoing data bytes, then writes the control register with a transaction kind and the start bit set. The controller hands a complete descriptor to the serial engine and holds host busy until the engine reports an outcome. When the engine answers, the controller stores any returned data and records the result in a sticky status byte. Software clears each status flag by writing 1 to it.

A running transaction is cancelled by writing the kill bit. The controller sends an abort pulse to the engine, drops busy and records the cancellation as a failure. Two auxiliary enables are kept and passed through to the engine: CRC checking and the 32-byte buffer. The engine itself is not part of this block.

Top module: `smbh_host`

## Requirements
- R1: After reset the status byte (offset 0), the control readback (offset 2) and both data registers (offsets 5 and 6) read 0x00, and `eng_start` and `eng_abort` are low.
- R2: A write to offset 2 with bit 6 set while idle sets host busy (status bit 0) from the next cycle. In that same first busy cycle `eng_start` is high, and only for that one cycle.
- R3: While host busy is set, writes to control, command (3), address (4), data-0 (5), data-1 (6) and block data (7) have no effect. A second start issues no `eng_start`, and the stored kind and address read back unchanged.
- R4: Control bits 4:2 select the kind: 0 quick, 1 byte, 2 byte-data, 3 word, 4 process call, 5 block, 6 I2C block. This code appears on `eng_kind`, and control bit 7 appears on `eng_pec`, for the whole transaction.
- R5: When `eng_done` arrives with neither `eng_nack` nor `eng_lost`, busy clears and the completion flag (status bit 1) sets on the same clock edge.
- R6: When `eng_done` arrives with `eng_nack`, status bit 2 sets. When it arrives with `eng_lost`, status bit 3 sets. In both cases busy clears and bit 1 stays clear.
- R7: A control write with bit 1 set while busy drives `eng_abort` high in the cycle of the write. At the next edge busy clears and the failed flag (status bit 4) sets. The same write while idle changes no status bit.
- R8: A start with kind code 7 does not start a transaction. No `eng_start` is issued, busy stays clear, and status bit 4 sets at the next edge.
- R9: `eng_addr` equals the address register (target in bits 7:1, read flag in bit 0), except for kind 6, where bit 0 is forced to 0. `eng_rnw` always carries address bit 0.
- R10: On a clean completion, data-0 takes `eng_rd0` for reads of kinds 1, 2, 3, 5 and 6. Data-1 takes `eng_rd1` for word reads. Process call loads both whatever the read flag says. Writes and quick transactions leave both data registers unchanged. Nothing is loaded on an error.
- R11: `eng_cmd` carries the command register, except for an I2C-block read, where it carries data-1.
- R12: Status bits 7, 4, 3, 2 and 1 are sticky, and writing 1 to a bit at offset 0 clears it while 0 leaves it. A pulse on `eng_byte` sets bit 7. Bits 6 and 5 read 0.
- R13: Offsets 3, 4, 7 and 8 read back the last byte written while idle. Offset 13 keeps bits 1:0, which drive `eng_crc_en` (bit 0) and `eng_buf32` (bit 1). Offset 12 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| eng_start | output | 1 | One-cycle request to the serial engine |
| eng_abort | output | 1 | Abort request to the serial engine |
| eng_kind | output | 3 | Transaction kind code |
| eng_addr | output | 8 | Address byte for the bus |
| eng_rnw | output | 1 | Read direction flag |
| eng_cmd | output | 8 | Command byte for the bus |
| eng_wd0 | output | 8 | Outgoing data-0 |
| eng_wd1 | output | 8 | Outgoing data-1 |
| eng_wblk | output | 8 | Outgoing block data byte |
| eng_pec | output | 1 | Packet error checking enable for this transaction |
| eng_crc_en | output | 1 | Hardware CRC check enable |
| eng_buf32 | output | 1 | 32-byte buffer enable |
| eng_done | input | 1 | Engine reports the end of the transaction |
| eng_nack | input | 1 | With `eng_done`: target gave no acknowledge |
| eng_lost | input | 1 | With `eng_done`: arbitration lost |
| eng_byte | input | 1 | Engine reports one byte moved |
| eng_rd0 | input | 8 | Returned low or single byte |
| eng_rd1 | input | 8 | Returned high byte |

## Verification
The bench builds the block with its default register address width of four bits, so every offset of the map is reachable. Kind, direction and engine outcome are small enough to sweep completely: all eight kind codes, both directions and all three outcomes. Each combination gets its own address, command and data bytes, derived arithmetically from the loop indices. This exposes every branch of the data-return rules, the I2C-block address and command substitution, and the reserved-code rejection. Directed sequences then cover kill while busy and while idle, a restart while busy, and flag clearing one bit at a time.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int BYTE_W = 8;

  // register offsets
  localparam int OFS_STS = 0;
  localparam int OFS_CTL = 2;
  localparam int OFS_CMD = 3;
  localparam int OFS_ADR = 4;
  localparam int OFS_D0  = 5;
  localparam int OFS_D1  = 6;
  localparam int OFS_BLK = 7;
  localparam int OFS_PEC = 8;
  localparam int OFS_AXS = 12;
  localparam int OFS_AXC = 13;

  // control bit positions
  localparam int CB_PEC   = 7;
  localparam int CB_START = 6;
  localparam int CB_KLO   = 2;
  localparam int CB_KILL  = 1;

  // sticky flag indices inside the flag vector
  localparam int NFLAG  = 5;
  localparam int FL_INTR = 0;
  localparam int FL_DEV  = 1;
  localparam int FL_BUS  = 2;
  localparam int FL_FAIL = 3;
  localparam int FL_BYTE = 4;

  typedef enum logic [2:0] {
    K_QUICK  = 3'd0,
    K_BYTE   = 3'd1,
    K_BDATA  = 3'd2,
    K_WORD   = 3'd3,
    K_PCALL  = 3'd4,
    K_BLOCK  = 3'd5,
    K_I2CBLK = 3'd6,
    K_RSVD   = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_e;
endpackage

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_wr,
  input  logic [2:0] start_code,
  input  logic       kill_wr,
  input  logic       eng_done,
  input  logic       eng_nack,
  input  logic       eng_lost,
  output logic       busy,
  output logic       eng_start,
  output logic       eng_abort,
  output logic       ev_ok,
  output logic       ev_nack,
  output logic       ev_lost,
  output logic       ev_kill,
  output logic       ev_bad
);
  seq_e st_q, st_d;
  logic idle, finish;

  assign idle   = (st_q == SQ_IDLE);
  assign busy   = !idle;
  assign finish = (st_q == SQ_WAIT) && eng_done && !kill_wr;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (start_wr && (kind_e'(start_code) != K_RSVD)) st_d = SQ_ISSUE;
      SQ_ISSUE: st_d = kill_wr ? SQ_IDLE : SQ_WAIT;
      SQ_WAIT:  if (kill_wr || eng_done) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign eng_start = (st_q == SQ_ISSUE);
  assign eng_abort = busy && kill_wr;
  assign ev_kill   = eng_abort;
  assign ev_bad    = idle && start_wr && (kind_e'(start_code) == K_RSVD);
  assign ev_ok     = finish && !eng_nack && !eng_lost;
  assign ev_nack   = finish && eng_nack;
  assign ev_lost   = finish && eng_lost;
endmodule

// File: rtl/smbh_flags.sv
module smbh_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q, d;
    // a new event wins over a clear written in the same cycle
    always_comb begin
      d = q;
      if (clr_en && clr_mask[i]) d = 1'b0;
      if (set_vec[i])            d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flags[i] = q;
  end
endmodule

// File: rtl/smbh_regfile.sv
module smbh_regfile
  import smbh_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              busy,
  input  logic [BYTE_W-1:0] sts_in,
  input  logic              upd_d0,
  input  logic              upd_d1,
  input  logic [BYTE_W-1:0] rd0,
  input  logic [BYTE_W-1:0] rd1,
  output logic [BYTE_W-1:0] rd_data,
  output kind_e             kind,
  output logic              pec_en,
  output logic [BYTE_W-1:0] adr,
  output logic [BYTE_W-1:0] cmd,
  output logic [BYTE_W-1:0] d0,
  output logic [BYTE_W-1:0] d1,
  output logic [BYTE_W-1:0] blk,
  output logic [1:0]        aux
);
  logic              host_ok;
  logic              we_ctl, we_cmd, we_adr, we_d0, we_d1, we_blk, we_pec, we_axc;
  kind_e             kind_q, kind_d;
  logic              pec_q, pec_d;
  logic [BYTE_W-1:0] adr_q, adr_d, cmd_q, cmd_d, d0_q, d0_d, d1_q, d1_d;
  logic [BYTE_W-1:0] blk_q, blk_d, pecv_q, pecv_d;
  logic [1:0]        aux_q, aux_d;

  assign host_ok = !busy;
  assign we_ctl  = wr_en && host_ok && (addr == AW'(OFS_CTL));
  assign we_cmd  = wr_en && host_ok && (addr == AW'(OFS_CMD));
  assign we_adr  = wr_en && host_ok && (addr == AW'(OFS_ADR));
  assign we_d0   = wr_en && host_ok && (addr == AW'(OFS_D0));
  assign we_d1   = wr_en && host_ok && (addr == AW'(OFS_D1));
  assign we_blk  = wr_en && host_ok && (addr == AW'(OFS_BLK));
  assign we_pec  = wr_en && (addr == AW'(OFS_PEC));
  assign we_axc  = wr_en && (addr == AW'(OFS_AXC));

  always_comb begin
    kind_d = we_ctl ? kind_e'(wr_data[CB_KLO +: 3]) : kind_q;
    pec_d  = we_ctl ? wr_data[CB_PEC] : pec_q;
    cmd_d  = we_cmd ? wr_data : cmd_q;
    adr_d  = we_adr ? wr_data : adr_q;
    blk_d  = we_blk ? wr_data : blk_q;
    pecv_d = we_pec ? wr_data : pecv_q;
    aux_d  = we_axc ? wr_data[1:0] : aux_q;
    d0_d   = d0_q;
    if (upd_d0)     d0_d = rd0;
    else if (we_d0) d0_d = wr_data;
    d1_d   = d1_q;
    if (upd_d1)     d1_d = rd1;
    else if (we_d1) d1_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_QUICK;
      pec_q  <= 1'b0;
      cmd_q  <= '0;
      adr_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      blk_q  <= '0;
      pecv_q <= '0;
      aux_q  <= '0;
    end else begin
      kind_q <= kind_d;
      pec_q  <= pec_d;
      cmd_q  <= cmd_d;
      adr_q  <= adr_d;
      d0_q   <= d0_d;
      d1_q   <= d1_d;
      blk_q  <= blk_d;
      pecv_q <= pecv_d;
      aux_q  <= aux_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      AW'(OFS_STS): rd_data = sts_in;
      AW'(OFS_CTL): rd_data = {pec_q, 2'b00, kind_q, 2'b00};
      AW'(OFS_CMD): rd_data = cmd_q;
      AW'(OFS_ADR): rd_data = adr_q;
      AW'(OFS_D0):  rd_data = d0_q;
      AW'(OFS_D1):  rd_data = d1_q;
      AW'(OFS_BLK): rd_data = blk_q;
      AW'(OFS_PEC): rd_data = pecv_q;
      AW'(OFS_AXC): rd_data = {6'b0, aux_q};
      default:      rd_data = '0;
    endcase
  end

  assign kind   = kind_q;
  assign pec_en = pec_q;
  assign adr    = adr_q;
  assign cmd    = cmd_q;
  assign d0     = d0_q;
  assign d1     = d1_q;
  assign blk    = blk_q;
  assign aux    = aux_q;
endmodule

// File: rtl/smbh_host.sv
module smbh_host
  import smbh_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          eng_start,
  output logic          eng_abort,
  output logic [2:0]    eng_kind,
  output logic [7:0]    eng_addr,
  output logic          eng_rnw,
  output logic [7:0]    eng_cmd,
  output logic [7:0]    eng_wd0,
  output logic [7:0]    eng_wd1,
  output logic [7:0]    eng_wblk,
  output logic          eng_pec,
  output logic          eng_crc_en,
  output logic          eng_buf32,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic          eng_lost,
  input  logic          eng_byte,
  input  logic [7:0]    eng_rd0,
  input  logic [7:0]    eng_rd1
);
  logic             start_wr_w, kill_wr_w, sts_wr_w;
  logic             busy_w;
  logic             ev_ok, ev_nack, ev_lost, ev_kill, ev_bad;
  logic [NFLAG-1:0] set_w, clr_w, fl_w;
  logic [7:0]       sts_w;
  kind_e            kind_w;
  logic             pec_w, rnw_w, is_i2c, rd_one, rd_two;
  logic             upd_d0_w, upd_d1_w;
  logic [7:0]       adr_w, cmd_w, d0_w, d1_w, blk_w;
  logic [1:0]       aux_w;

  assign start_wr_w = reg_wr && (reg_addr == AW'(OFS_CTL)) && reg_wdata[CB_START];
  assign kill_wr_w  = reg_wr && (reg_addr == AW'(OFS_CTL)) && reg_wdata[CB_KILL];
  assign sts_wr_w   = reg_wr && (reg_addr == AW'(OFS_STS));

  smbh_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_wr   (start_wr_w),
    .start_code (reg_wdata[CB_KLO +: 3]),
    .kill_wr    (kill_wr_w),
    .eng_done   (eng_done),
    .eng_nack   (eng_nack),
    .eng_lost   (eng_lost),
    .busy       (busy_w),
    .eng_start  (eng_start),
    .eng_abort  (eng_abort),
    .ev_ok      (ev_ok),
    .ev_nack    (ev_nack),
    .ev_lost    (ev_lost),
    .ev_kill    (ev_kill),
    .ev_bad     (ev_bad)
  );

  always_comb begin
    set_w          = '0;
    set_w[FL_INTR] = ev_ok;
    set_w[FL_DEV]  = ev_nack;
    set_w[FL_BUS]  = ev_lost;
    set_w[FL_FAIL] = ev_kill || ev_bad;
    set_w[FL_BYTE] = eng_byte;
    clr_w          = {reg_wdata[7], reg_wdata[4], reg_wdata[3], reg_wdata[2], reg_wdata[1]};
  end

  smbh_flags #(.N(NFLAG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (sts_wr_w),
    .clr_mask (clr_w),
    .set_vec  (set_w),
    .flags    (fl_w)
  );

  assign sts_w = {fl_w[FL_BYTE], 2'b00, fl_w[FL_FAIL], fl_w[FL_BUS],
                  fl_w[FL_DEV], fl_w[FL_INTR], busy_w};

  // which data registers a clean finish loads
  assign rnw_w  = adr_w[0];
  assign is_i2c = (kind_w == K_I2CBLK);
  always_comb begin
    rd_one = 1'b0;
    rd_two = 1'b0;
    unique case (kind_w)
      K_BYTE, K_BDATA, K_BLOCK, K_I2CBLK: rd_one = rnw_w;
      K_WORD:                             begin rd_one = rnw_w; rd_two = rnw_w; end
      K_PCALL:                            begin rd_one = 1'b1;  rd_two = 1'b1;  end
      default:                            ;
    endcase
  end
  assign upd_d0_w = ev_ok && rd_one;
  assign upd_d1_w = ev_ok && rd_two;

  smbh_regfile #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wr_data (reg_wdata),
    .busy    (busy_w),
    .sts_in  (sts_w),
    .upd_d0  (upd_d0_w),
    .upd_d1  (upd_d1_w),
    .rd0     (eng_rd0),
    .rd1     (eng_rd1),
    .rd_data (reg_rdata),
    .kind    (kind_w),
    .pec_en  (pec_w),
    .adr     (adr_w),
    .cmd     (cmd_w),
    .d0      (d0_w),
    .d1      (d1_w),
    .blk     (blk_w),
    .aux     (aux_w)
  );

  assign eng_kind   = kind_w;
  assign eng_rnw    = rnw_w;
  assign eng_addr   = is_i2c ? {adr_w[7:1], 1'b0} : adr_w;
  assign eng_cmd    = (is_i2c && rnw_w) ? d1_w : cmd_w;
  assign eng_wd0    = d0_w;
  assign eng_wd1    = d1_w;
  assign eng_wblk   = blk_w;
  assign eng_pec    = pec_w;
  assign eng_crc_en = aux_w[0];
  assign eng_buf32  = aux_w[1];
endmodule

// File: rtl/smbh_host_chk.sv
module smbh_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [7:0] sts,
  input logic       start_wr,
  input logic [2:0] start_code,
  input logic       kill_wr,
  input logic       eng_start,
  input logic       eng_abort,
  input logic       eng_done,
  input logic       eng_nack,
  input logic       eng_lost
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy); // R2
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !$past(busy)); // R3
  AST_DONE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_start && eng_done && !eng_nack && !eng_lost && !kill_wr)
      |=> (!busy && sts[1])); // R5
  AST_DONE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_start && eng_done && eng_nack && !kill_wr)
      |=> (!busy && sts[2] && !sts[1])); // R6
  AST_KILL_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kill_wr) |=> (!busy && sts[4])); // R7
  AST_ABORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> busy); // R7
  AST_RSVD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_wr && (start_code == 3'd7)) |=> (!busy && sts[4])); // R8
endmodule

bind smbh_host smbh_host_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_w),
  .sts        (sts_w),
  .start_wr   (start_wr_w),
  .start_code (reg_wdata[4:2]),
  .kill_wr    (kill_wr_w),
  .eng_start  (eng_start),
  .eng_abort  (eng_abort),
  .eng_done   (eng_done),
  .eng_nack   (eng_nack),
  .eng_lost   (eng_lost)
);

// File: tb/sim_smbh_host.sv
module sim_smbh_host;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic eng_start, eng_abort, eng_rnw, eng_pec, eng_crc_en, eng_buf32;
  logic [2:0] eng_kind;
  logic [7:0] eng_addr, eng_cmd, eng_wd0, eng_wd1, eng_wblk;
  logic eng_done = 1'b0, eng_nack = 1'b0, eng_lost = 1'b0, eng_byte = 1'b0;
  logic [7:0] eng_rd0 = '0, eng_rd1 = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smbh_host #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_start(eng_start), .eng_abort(eng_abort), .eng_kind(eng_kind),
    .eng_addr(eng_addr), .eng_rnw(eng_rnw), .eng_cmd(eng_cmd),
    .eng_wd0(eng_wd0), .eng_wd1(eng_wd1), .eng_wblk(eng_wblk),
    .eng_pec(eng_pec), .eng_crc_en(eng_crc_en), .eng_buf32(eng_buf32),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_lost(eng_lost),
    .eng_byte(eng_byte), .eng_rd0(eng_rd0), .eng_rd1(eng_rd1)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(v);
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  // combinational read, used at a negedge
  task automatic peek(input int a, output int v);
    reg_addr = AW'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic finish_xact(input bit nk, input bit lo, input int r0, input int r1);
    @(negedge clk);
    eng_done = 1'b1; eng_nack = nk; eng_lost = lo;
    eng_rd0 = 8'(r0); eng_rd1 = 8'(r1);
    @(posedge clk);
    #1 eng_done = 1'b0; eng_nack = 1'b0; eng_lost = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(0, v); chk("R1 status", v, 0);
    peek(2, v); chk("R1 control", v, 0);
    peek(5, v); chk("R1 data0", v, 0);
    peek(6, v); chk("R1 data1", v, 0);
    chk("R1 eng_start", int'(eng_start), 0);
    chk("R1 eng_abort", int'(eng_abort), 0);

    // R13 register readback and aux enables
    wr(3, 8'h3C); wr(4, 8'hA5); wr(7, 8'h77); wr(8, 8'h9E); wr(13, 8'hFF);
    @(negedge clk);
    peek(3, v);  chk("R13 command", v, 8'h3C);
    peek(4, v);  chk("R13 address", v, 8'hA5);
    peek(7, v);  chk("R13 block", v, 8'h77);
    peek(8, v);  chk("R13 pec byte", v, 8'h9E);
    peek(13, v); chk("R13 aux", v, 8'h03);
    peek(12, v); chk("R13 aux status", v, 0);
    chk("R13 crc_en", int'(eng_crc_en), 1);
    chk("R13 buf32", int'(eng_buf32), 1);
    chk("R13 wblk", int'(eng_wblk), 8'h77);
    wr(13, 8'h02);
    @(negedge clk);
    chk("R13 crc_en off", int'(eng_crc_en), 0);
    chk("R13 buf32 on", int'(eng_buf32), 1);

    // sweep: kind x direction x outcome
    for (int t = 0; t < 8; t++) begin
      for (int r = 0; r < 2; r++) begin
        for (int o = 0; o < 3; o++) begin
          int a7, cm, w0, w1, r0, r1, ea, ec, e0, e1, es;
          bit ld0, ld1;
          a7 = (t * 13 + r * 5 + o * 3 + 9) % 128;
          cm = (t * 31 + o + 1) % 256;
          w0 = (8'hA0 + t * 2 + o) % 256;
          w1 = (8'h50 + t * 3 + r) % 256;
          r0 = (8'h11 * (o + 1) + t) % 256;
          r1 = (8'h03 + t * 16 + r) % 256;
          wr(4, a7 * 2 + r); wr(3, cm); wr(5, w0); wr(6, w1); wr(0, 8'hFF);
          wr(2, (t % 2) * 128 + 64 + t * 4);
          @(negedge clk);
          if (t == 7) begin
            chk("R8 no start", int'(eng_start), 0);
            peek(0, v); chk("R8 status", v, 8'h10);
          end else begin
            chk("R2 start pulse", int'(eng_start), 1);
            peek(0, v); chk("R2 busy", v & 1, 1);
            chk("R4 kind", int'(eng_kind), t);
            chk("R4 pec", int'(eng_pec), t % 2);
            ea = (t == 6) ? a7 * 2 : a7 * 2 + r;
            chk("R9 addr byte", int'(eng_addr), ea);
            chk("R9 rnw", int'(eng_rnw), r);
            ec = (t == 6 && r == 1) ? w1 : cm;
            chk("R11 command out", int'(eng_cmd), ec);
            chk("R10 wd0", int'(eng_wd0), w0);
            @(negedge clk);
            chk("R2 start one cycle", int'(eng_start), 0);
            finish_xact(o == 1, o == 2, r0, r1);
            @(negedge clk);
            es = (o == 0) ? 8'h02 : ((o == 1) ? 8'h04 : 8'h08);
            peek(0, v);
            if (o == 0) chk("R5 status", v, es);
            else        chk("R6 status", v, es);
            ld0 = (o == 0) && (t == 4 || (r == 1 && (t == 1 || t == 2 || t == 3 || t == 5 || t == 6)));
            ld1 = (o == 0) && (t == 4 || (r == 1 && t == 3));
            e0 = ld0 ? r0 : w0;
            e1 = ld1 ? r1 : w1;
            peek(5, v); chk("R10 data0", v, e0);
            peek(6, v); chk("R10 data1", v, e1);
          end
        end
      end
    end

    // R7 kill while busy
    wr(0, 8'hFF); wr(4, 8'h20);
    wr(2, 8'h44);
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(2); reg_wdata = 8'h02;
    #1 chk("R7 abort pulse", int'(eng_abort), 1);
    @(posedge clk);
    #1 reg_wr = 1'b0;
    @(negedge clk);
    chk("R7 abort drop", int'(eng_abort), 0);
    peek(0, v); chk("R7 failed and idle", v, 8'h10);

    // R7 kill while idle: no effect
    wr(0, 8'hFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(2); reg_wdata = 8'h02;
    #1 chk("R7 idle no abort", int'(eng_abort), 0);
    @(posedge clk);
    #1 reg_wr = 1'b0;
    @(negedge clk);
    peek(0, v); chk("R7 idle status", v, 0);

    // R3 restart and register writes while busy
    wr(4, 8'h30);
    wr(2, 8'h44);
    @(negedge clk);
    chk("R3 first start", int'(eng_start), 1);
    wr(2, 8'hCC);
    @(negedge clk);
    chk("R3 no second start", int'(eng_start), 0);
    peek(2, v); chk("R3 kind kept", v, 8'h04);
    wr(4, 8'h55);
    @(negedge clk);
    peek(4, v); chk("R3 address kept", v, 8'h30);
    peek(0, v); chk("R3 still busy", v, 8'h01);
    finish_xact(1'b0, 1'b0, 8'h00, 8'h00);
    @(negedge clk);
    peek(0, v); chk("R5 after restart", v, 8'h02);

    // R12 byte-done and bitwise clearing
    wr(0, 8'hFF);
    @(negedge clk);
    eng_byte = 1'b1;
    @(posedge clk);
    #1 eng_byte = 1'b0;
    @(negedge clk);
    peek(0, v); chk("R12 byte done", v, 8'h80);
    wr(2, 8'h40);
    @(negedge clk);
    finish_xact(1'b0, 1'b0, 8'h00, 8'h00);
    @(negedge clk);
    peek(0, v); chk("R12 accumulate", v, 8'h82);
    wr(0, 8'h02);
    @(negedge clk);
    peek(0, v); chk("R12 clear bit1", v, 8'h80);
    wr(0, 8'h00);
    @(negedge clk);
    peek(0, v); chk("R12 zero write", v, 8'h80);
    wr(0, 8'h80);
    @(negedge clk);
    peek(0, v); chk("R12 clear bit7", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule